// File: doc/BRIEF.md
# Write Cycle Qualification Filter

This block stands between the raw, asynchronous control pins of a memory device and its command register, and decides which bus activity counts as a real write. The three active-low controls (chip enable, write enable, output enable) are brought into the clock domain by a two-flop synchronizer. Each then passes through its own pulse-width filter, which passes a new level only once it has held for a set number of clock cycles. A write is taken when the filtered write enable rises after a cycle in which chip enable and write enable were low and output enable was high, and chip enable is still low and output enable still high at that rise. The block then gives the command decoder a single-cycle strobe.

Two supply-related inputs gate the path. While the low-supply indicator is high, all writes are dropped and a reset request goes to the internal state machine, so that the command register and the program/erase logic go back to reading the array. The same reset request is raised while the power-up-done flag is low. A write whose enables were already active while power-up or lockout was in progress is refused on its following rising edge. The path re-arms only after the filtered write enable has been seen high with power good.

Top module: `write_qual_filter`

## Requirements
- R1: With chip enable low, write enable low and output enable high (all filtered), a rise of write enable while chip enable stays low and output enable stays high produces exactly one `wr_strobe_o` pulse, one clock wide. The pulse is registered `GLITCH_CYC`+3 clock edges after the raw write-enable rise: two synchronizer stages, `GLITCH_CYC` filter edges and one output register.
- R2: No strobe is produced when output enable is low, when chip enable is high, or when write enable only falls. A write enable that rises together with chip enable gives no strobe.
- R3: A level change on any control input that lasts fewer than `GLITCH_CYC` clock cycles is ignored. A change held for `GLITCH_CYC` cycles or longer is taken.
- R4: While `low_supply_i` is 1, no strobe is produced and `sm_reset_o` is 1 from the following clock. A write whose write enable was low when lockout ended is not taken on its next rise.
- R5: While `pwr_done_i` is 0, `sm_reset_o` is 1 from the following clock and no strobe is produced. A write with chip enable and write enable low and output enable high during power-up is not taken on the rise that follows power-up.
- R6: After power-up or lockout ends, writes are taken again once filtered write enable has been high with `pwr_done_i` at 1 and `low_supply_i` at 0.
- R7: Synchronous reset `rst` forces `wr_strobe_o` to 0 and `sm_reset_o` to 1, sets all filtered controls to inactive (high) and clears the armed state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n_i | input | 1 | Chip enable pin, active low, asynchronous |
| we_n_i | input | 1 | Write enable pin, active low, asynchronous |
| oe_n_i | input | 1 | Output enable pin, active low, asynchronous |
| low_supply_i | input | 1 | Supply below lockout level, synchronous to clk |
| pwr_done_i | input | 1 | Power-up complete, synchronous to clk |
| wr_strobe_o | output | 1 | One-cycle accepted-write strobe |
| sm_reset_o | output | 1 | Reset request for command register and program/erase state |

## Verification
The properties assume that `low_supply_i` and `pwr_done_i` are already synchronous to `clk`. They also assume that `pwr_done_i` stays low for at least `GLITCH_CYC`+3 cycles after reset while the controls settle. Otherwise a write enable held low through reset would look inactive to the filter and could arm early. The stimulus changes the two supply flags only at falling clock edges and holds `pwr_done_i` low for the first twelve cycles. Every intended control level lasts at least `GLITCH_CYC` cycles, and only the glitch vectors are deliberately shorter.

// File: rtl/wqf_pkg.sv
package wqf_pkg;
  localparam int CTL_W  = 3;
  localparam int IDX_CE = 0;
  localparam int IDX_WE = 1;
  localparam int IDX_OE = 2;
  localparam logic [CTL_W-1:0] CTL_IDLE = '1;
endpackage

// File: rtl/wqf_sync.sv
module wqf_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wqf_deglitch.sv
module wqf_deglitch #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

  logic             lvl;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl <= 1'b1;
      cnt <= '0;
    end else if (din == lvl) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      lvl <= din;
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign dout = lvl;
endmodule

// File: rtl/wqf_qualify.sv
module wqf_qualify (
  input  logic clk,
  input  logic rst,
  input  logic ce_f,
  input  logic we_f,
  input  logic oe_f,
  input  logic low_supply,
  input  logic pwr_done,
  output logic strobe,
  output logic sm_reset
);
  logic we_q;
  logic wr_act_q;
  logic arm_q;
  logic strobe_q;
  logic smrst_q;
  logic we_rise;
  logic power_ok;

  assign we_rise  = we_f & ~we_q;
  assign power_ok = pwr_done & ~low_supply;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q     <= 1'b1;
      wr_act_q <= 1'b0;
      arm_q    <= 1'b0;
      strobe_q <= 1'b0;
      smrst_q  <= 1'b1;
    end else begin
      we_q     <= we_f;
      wr_act_q <= ~ce_f & ~we_f & oe_f;
      smrst_q  <= ~power_ok;
      strobe_q <= we_rise & wr_act_q & ~ce_f & oe_f & arm_q & power_ok;
      if (!power_ok)
        arm_q <= 1'b0;
      else if (we_f)
        arm_q <= 1'b1;
    end
  end

  assign strobe   = strobe_q;
  assign sm_reset = smrst_q;
endmodule

// File: rtl/write_qual_filter.sv
module write_qual_filter
  import wqf_pkg::*;
#(
  parameter int GLITCH_CYC  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_n_i,
  input  logic we_n_i,
  input  logic oe_n_i,
  input  logic low_supply_i,
  input  logic pwr_done_i,
  output logic wr_strobe_o,
  output logic sm_reset_o
);
  logic [CTL_W-1:0] ctl_raw;
  logic [CTL_W-1:0] ctl_s;
  logic [CTL_W-1:0] ctl_f;

  assign ctl_raw[IDX_CE] = ce_n_i;
  assign ctl_raw[IDX_WE] = we_n_i;
  assign ctl_raw[IDX_OE] = oe_n_i;

  wqf_sync #(
    .W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  for (genvar g = 0; g < CTL_W; g++) begin : g_flt
    wqf_deglitch #(.CYC(GLITCH_CYC)) u_flt (
      .clk(clk), .rst(rst), .din(ctl_s[g]), .dout(ctl_f[g])
    );
  end

  wqf_qualify u_qual (
    .clk(clk),
    .rst(rst),
    .ce_f(ctl_f[IDX_CE]),
    .we_f(ctl_f[IDX_WE]),
    .oe_f(ctl_f[IDX_OE]),
    .low_supply(low_supply_i),
    .pwr_done(pwr_done_i),
    .strobe(wr_strobe_o),
    .sm_reset(sm_reset_o)
  );
endmodule

// File: rtl/wqf_checker.sv
module wqf_checker (
  input logic clk,
  input logic rst,
  input logic low_supply_i,
  input logic pwr_done_i,
  input logic ce_f,
  input logic we_f,
  input logic oe_f,
  input logic we_s,
  input logic wr_strobe_o,
  input logic sm_reset_o
);
  assert_strobe_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_o |=> !wr_strobe_o);

  assert_strobe_after_rise_R1: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_o |-> ($past(we_f) && !$past(we_f, 2)));

  assert_no_strobe_inhibit_R2: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_o |-> (!$past(ce_f) && $past(oe_f)));

  assert_filter_follows_sync_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(we_f) |-> ($past(we_s) == we_f));

  assert_lockout_no_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    low_supply_i |=> !wr_strobe_o);

  assert_lockout_reset_R4: assert property (@(posedge clk) disable iff (rst)
    low_supply_i |=> sm_reset_o);

  assert_powerup_reset_R5: assert property (@(posedge clk) disable iff (rst)
    !pwr_done_i |=> (sm_reset_o && !wr_strobe_o));
endmodule

bind write_qual_filter wqf_checker u_chk (
  .clk(clk),
  .rst(rst),
  .low_supply_i(low_supply_i),
  .pwr_done_i(pwr_done_i),
  .ce_f(ctl_f[wqf_pkg::IDX_CE]),
  .we_f(ctl_f[wqf_pkg::IDX_WE]),
  .oe_f(ctl_f[wqf_pkg::IDX_OE]),
  .we_s(ctl_s[wqf_pkg::IDX_WE]),
  .wr_strobe_o(wr_strobe_o),
  .sm_reset_o(sm_reset_o)
);

// File: tb/sim_write_qual_filter.sv
`timescale 1ns/1ps
module sim_write_qual_filter;
  localparam int GC = 4;
  localparam int NV = 43;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic low = 1'b0, pd = 1'b0;
  logic wr_strobe_o, sm_reset_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  write_qual_filter #(.GLITCH_CYC(GC)) u0 (
    .clk(clk), .rst(rst), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .low_supply_i(low), .pwr_done_i(pd),
    .wr_strobe_o(wr_strobe_o), .sm_reset_o(sm_reset_o)
  );

  // {ce_n, we_n, oe_n, low, pd, hold[7:0], strobes[1:0], sm_reset}
  localparam logic [15:0] VEC [NV] = '{
    {5'b11100, 8'd12, 2'd0, 1'b1},  //  0 power-up in progress R5
    {5'b11101, 8'd12, 2'd0, 1'b0},  //  1 power good, arms R6
    {5'b00101, 8'd12, 2'd0, 1'b0},  //  2 write active
    {5'b01101, 8'd12, 2'd1, 1'b0},  //  3 we rise -> strobe R1
    {5'b11101, 8'd12, 2'd0, 1'b0},  //  4 idle
    {5'b00001, 8'd12, 2'd0, 1'b0},  //  5 oe low R2
    {5'b01001, 8'd12, 2'd0, 1'b0},  //  6 rise with oe low R2
    {5'b10101, 8'd12, 2'd0, 1'b0},  //  7 ce high R2
    {5'b11101, 8'd12, 2'd0, 1'b0},  //  8 rise with ce high R2
    {5'b00101, 8'd12, 2'd0, 1'b0},  //  9 write active
    {5'b01101, 8'd3,  2'd0, 1'b0},  // 10 short we high glitch R3
    {5'b00101, 8'd12, 2'd0, 1'b0},  // 11
    {5'b01101, 8'd12, 2'd1, 1'b0},  // 12 real rise R3
    {5'b00101, 8'd3,  2'd0, 1'b0},  // 13 short we low glitch R3
    {5'b01101, 8'd12, 2'd0, 1'b0},  // 14 no strobe R3
    {5'b00111, 8'd12, 2'd0, 1'b1},  // 15 lockout R4
    {5'b01111, 8'd12, 2'd0, 1'b1},  // 16 rise in lockout R4
    {5'b11101, 8'd12, 2'd0, 1'b0},  // 17 recover, arms
    {5'b00111, 8'd12, 2'd0, 1'b1},  // 18 write into lockout R4
    {5'b00101, 8'd12, 2'd0, 1'b0},  // 19 lockout ends, we still low
    {5'b01101, 8'd12, 2'd0, 1'b0},  // 20 rise refused R4
    {5'b11101, 8'd12, 2'd0, 1'b0},  // 21
    {5'b00101, 8'd12, 2'd0, 1'b0},  // 22
    {5'b01101, 8'd12, 2'd1, 1'b0},  // 23 accepted again R6
    {5'b00100, 8'd12, 2'd0, 1'b1},  // 24 write during power-up R5
    {5'b00101, 8'd12, 2'd0, 1'b0},  // 25 power done, we low
    {5'b01101, 8'd12, 2'd0, 1'b0},  // 26 rise refused R5
    {5'b11101, 8'd12, 2'd0, 1'b0},  // 27
    {5'b00101, 8'd12, 2'd0, 1'b0},  // 28
    {5'b01101, 8'd12, 2'd1, 1'b0},  // 29 accepted R6
    {5'b00101, 8'd12, 2'd0, 1'b0},  // 30
    {5'b00001, 8'd3,  2'd0, 1'b0},  // 31 oe low glitch R3
    {5'b00101, 8'd12, 2'd0, 1'b0},  // 32
    {5'b01101, 8'd12, 2'd1, 1'b0},  // 33 strobe despite oe glitch R3
    {5'b00101, 8'd12, 2'd0, 1'b0},  // 34
    {5'b11101, 8'd12, 2'd0, 1'b0},  // 35 ce and we rise together R2
    {5'b00101, 8'd12, 2'd0, 1'b0},  // 36
    {5'b01101, 8'd4,  2'd0, 1'b0},  // 37 we high exactly GC R3
    {5'b00101, 8'd12, 2'd1, 1'b0},  // 38 strobe lands here R3
    {5'b11101, 8'd12, 2'd0, 1'b0},  // 39 joint rise R2
    {5'b01101, 8'd12, 2'd0, 1'b0},  // 40 ce low alone
    {5'b00101, 8'd4,  2'd0, 1'b0},  // 41 we low exactly GC R3
    {5'b01101, 8'd12, 2'd1, 1'b0}   // 42 accepted R3
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int scnt;
    int first;
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", "strobe in reset", int'(wr_strobe_o), 0);
    check("R7", "sm_reset in reset", int'(sm_reset_o), 1);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      {ce_n, we_n, oe_n, low, pd} = VEC[v][15:11];
      scnt = 0;
      for (int c = 0; c < int'(VEC[v][10:3]); c++) begin
        @(negedge clk);
        if (wr_strobe_o) scnt++;
      end
      check($sformatf("R1-R6 vec%0d", v), "strobes", scnt, int'(VEC[v][2:1]));
      check($sformatf("R4/R5 vec%0d", v), "sm_reset", int'(sm_reset_o), int'(VEC[v][0]));
    end

    // R1: latency and width of a single strobe
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    repeat (12) @(negedge clk);
    we_n = 1'b1;
    first = 0; scnt = 0;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (wr_strobe_o) begin
        scnt++;
        if (first == 0) first = k;
      end
    end
    check("R1", "strobe latency", first, GC + 3);
    check("R1", "strobe width", scnt, 1);

    // R7: reset in mid-operation
    ce_n = 1'b1;
    repeat (12) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R7", "sm_reset on reset", int'(sm_reset_o), 1);
    check("R7", "strobe on reset", int'(wr_strobe_o), 0);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    check("R7", "sm_reset after release", int'(sm_reset_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule